// File: doc/BRIEF.md
# Fixed-Point to Single-Precision Float Converter

This block turns a signed fixed-point number into a 32-bit IEEE 754 single-precision word. The magnitude arrives split into two unsigned halves: a 32-bit whole part and a 32-bit fraction part, with the binary point between them. The sign comes on its own wire. The block treats the two halves as one 64-bit magnitude and finds its most significant set bit. That bit's distance from the binary point becomes the exponent, stored with a bias of 127. The bits just below it, left-justified, become the 23-bit fraction field.

Fraction bits that fall below the 23-bit field are dropped, so the result is truncated, not rounded. When fewer than 23 bits remain below the leading one, the field is filled with zeros at the bottom. A zero magnitude gives a zero with the input's sign.

The block is used as a one-stage pipeline element. A word presented with the input strobe appears, converted, on the cycle after, together with an output strobe. The output word then holds until the next accepted input.

Top module: `fixToFloat`

## Requirements
- R1: Bit 31 of `outFloat` equals the `inSign` value that was accepted with it (0 positive, 1 negative).
- R2: For a nonzero magnitude M = {inInt, inFrac}, let k be the bit index of its highest set bit (0..63). The exponent field `outFloat[30:23]` equals k − 32 + 127.
- R3: `outFloat[22:0]` holds the 23 bits of M directly below the leading one, most significant first; any lower bits are discarded (truncation).
- R4: When k < 23, the fraction field holds the k bits below the leading one in its top positions, with zeros filling the rest.
- R5: When inInt and inFrac are both zero, `outFloat[30:0]` is zero and bit 31 still follows `inSign`.
- R6: `outValid` is high in exactly the cycle after each cycle in which `inValid` was high, and is low otherwise.
- R7: While `inValid` is low, `outFloat` keeps its last value.
- R8: During and right after reset, `outValid` and `outFloat` are zero.
- R9: A whole part of 2815 with any fraction gives an exponent field of 138.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Input word present this cycle |
| inSign | input | 1 | Sign of the input, 1 for negative |
| inInt | input | 32 | Unsigned whole part |
| inFrac | input | 32 | Fraction part, MSB weight 2^-1 |
| outValid | output | 1 | Converted word present this cycle |
| outFloat | output | 32 | Single-precision result: sign, exponent, fraction |

## Verification
The assertions check the timing and framing rules on every cycle:
- the output strobe trails the input strobe by one cycle,
- the sign passes through,
- the word holds between inputs,
- a zero magnitude gives a zeroed exponent and fraction,
- every nonzero result has an exponent inside the range that a 64-bit magnitude can reach.

The exact exponent and fraction values for a given leading-one position can only be shown by the bench's scenarios. These include truncation of long fractions, zero padding for tiny values, leading ones at both ends of the vector, and the 2815 example.

// File: rtl/fxf_pkg.sv
package fxf_pkg;
  localparam int INT_W  = 32;
  localparam int FRAC_W = 32;
  localparam int EXP_W  = 8;
  localparam int MAN_W  = 23;
  localparam int BIAS   = 127;
  localparam int MAG_W  = INT_W + FRAC_W;
  localparam int IDX_W  = $clog2(MAG_W);
  localparam int FLT_W  = 1 + EXP_W + MAN_W;

  typedef struct packed {
    logic load;
    logic clear;
  } convStrobes_t;
endpackage

// File: rtl/fxfLeadOne.sv
module fxfLeadOne #(
  parameter int WIDTH = 64,
  localparam int IW = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] vec,
  output logic [IW-1:0]    idx,
  output logic             found
);
  always_comb begin
    idx   = '0;
    found = 1'b0;
    for (int i = 0; i < WIDTH; i++) begin
      if (vec[i]) begin
        idx   = IW'(i);
        found = 1'b1;
      end
    end
  end
endmodule

// File: rtl/fxfControl.sv
module fxfControl
  import fxf_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  output convStrobes_t stb,
  output logic         outValid
);
  always_comb begin
    stb.clear = !rstN;
    stb.load  = rstN && inValid;
  end

  always_ff @(posedge clk) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end
endmodule

// File: rtl/fxfDatapath.sv
module fxfDatapath
  import fxf_pkg::*;
(
  input  logic              clk,
  input  convStrobes_t      stb,
  input  logic              inSign,
  input  logic [INT_W-1:0]  inInt,
  input  logic [FRAC_W-1:0] inFrac,
  output logic [FLT_W-1:0]  outFloat
);
  localparam int EXP_OFS = BIAS - FRAC_W;

  logic [MAG_W-1:0] mag;
  logic [MAG_W-1:0] normMag;
  logic [IDX_W-1:0] leadIdx;
  logic             nonZero;
  logic [EXP_W-1:0] expField;
  logic [MAN_W-1:0] manField;
  logic [FLT_W-1:0] packed_w;

  assign mag = {inInt, inFrac};

  fxfLeadOne #(.WIDTH(MAG_W)) uLead (
    .vec  (mag),
    .idx  (leadIdx),
    .found(nonZero)
  );

  always_comb begin
    normMag  = mag << (IDX_W'(MAG_W - 1) - leadIdx);
    manField = normMag[MAG_W-2 -: MAN_W];
    expField = EXP_W'(leadIdx) + EXP_W'(EXP_OFS);
    if (nonZero) packed_w = {inSign, expField, manField};
    else         packed_w = {inSign, {(EXP_W + MAN_W){1'b0}}};
  end

  always_ff @(posedge clk) begin
    if (stb.clear)     outFloat <= '0;
    else if (stb.load) outFloat <= packed_w;
  end
endmodule

// File: rtl/fixToFloat.sv
module fixToFloat
  import fxf_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic        inSign,
  input  logic [31:0] inInt,
  input  logic [31:0] inFrac,
  output logic        outValid,
  output logic [31:0] outFloat
);
  convStrobes_t stb;

  fxfControl uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .stb     (stb),
    .outValid(outValid)
  );

  fxfDatapath uData (
    .clk     (clk),
    .stb     (stb),
    .inSign  (inSign),
    .inInt   (inInt),
    .inFrac  (inFrac),
    .outFloat(outFloat)
  );
endmodule

// File: rtl/fixToFloatChecker.sv
module fixToFloatChecker (
  input logic        clk,
  input logic        rstN,
  input logic        inValid,
  input logic        inSign,
  input logic [31:0] inInt,
  input logic [31:0] inFrac,
  input logic        outValid,
  input logic [31:0] outFloat
);
  a_r6_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  a_r6_no_spurious: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);
  a_r1_sign_passes: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outFloat[31] == $past(inSign));
  a_r7_hold: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> $stable(outFloat));
  a_r5_zero_word: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inInt == 32'd0 && inFrac == 32'd0) |=> outFloat[30:0] == 31'd0);
  a_r2_exp_range: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outFloat[30:0] != 31'd0) |->
      (outFloat[30:23] >= 8'd95 && outFloat[30:23] <= 8'd158));
endmodule

bind fixToFloat fixToFloatChecker uChk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inSign(inSign),
  .inInt(inInt), .inFrac(inFrac), .outValid(outValid), .outFloat(outFloat)
);

// File: tb/fixToFloat_test.sv
module fixToFloat_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic        inSign = 1'b0;
  logic [31:0] inInt = '0;
  logic [31:0] inFrac = '0;
  logic        outValid;
  logic [31:0] outFloat;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic [31:0] word;
    string       tag;
  } expItem_t;

  expItem_t    expQ[$];
  logic [31:0] lastWord = '0;

  always #10 clk = ~clk;

  fixToFloat uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inSign(inSign),
    .inInt(inInt), .inFrac(inFrac), .outValid(outValid), .outFloat(outFloat)
  );

  function automatic logic [31:0] refConv(logic s, logic [31:0] wi, logic [31:0] wf);
    logic [63:0] m;
    logic [63:0] n;
    int k;
    m = {wi, wf};
    k = -1;
    for (int i = 0; i < 64; i++) if (m[i]) k = i;
    if (k < 0) return {s, 31'd0};
    n = m << (63 - k);
    return {s, 8'(k - 32 + 127), n[62:40]};
  endfunction

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(logic s, logic [31:0] wi, logic [31:0] wf, string tag);
    expItem_t it;
    @(posedge clk);
    #2;
    it.word = refConv(s, wi, wf);
    it.tag  = tag;
    expQ.push_back(it);
    inValid = 1'b1; inSign = s; inInt = wi; inFrac = wf;
    @(posedge clk);
    #2;
    inValid = 1'b0; inSign = ~s; inInt = ~wi; inFrac = wf ^ 32'h1234_5678;
  endtask

  // monitor: compare every output word against the scoreboard, check hold otherwise
  always @(negedge clk) begin
    if (rstN && !done) begin
      if (outValid) begin
        if (expQ.size() == 0) check(1'b0, "R6 unexpected outValid", outFloat, 32'h0);
        else begin
          expItem_t it;
          it = expQ.pop_front();
          check(outFloat == it.word, it.tag, outFloat, it.word);
        end
        lastWord = outFloat;
      end else begin
        check(outFloat == lastWord, "R7 hold while idle", outFloat, lastWord);
      end
    end
  end

  initial begin
    fork
      begin
        repeat (3) @(posedge clk);
        #2;
        check(outValid == 1'b0, "R8 reset outValid", {31'd0, outValid}, 32'd0);
        check(outFloat == 32'd0, "R8 reset outFloat", outFloat, 32'd0);
        rstN = 1'b1;
        @(negedge clk);
        check(outValid == 1'b0, "R8 after reset outValid", {31'd0, outValid}, 32'd0);

        drive(1'b0, 32'd2815, 32'h8CCC_CCCC, "R2 R3 2815.55 positive");
        @(negedge clk);
        check(outFloat[30:23] == 8'd138, "R9 exponent 138", {24'd0, outFloat[30:23]}, 32'd138);
        drive(1'b1, 32'd2815, 32'h0000_0000, "R1 negative sign, R9");
        drive(1'b1, 32'd185, 32'hBA00_0000, "R1 R3 negative 185.x");
        drive(1'b0, 32'd1, 32'd0, "R2 one gives exp 127");
        drive(1'b0, 32'h8000_0000, 32'hFFFF_FFFF, "R2 R3 top bit, truncation");
        drive(1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R3 all ones truncated");
        drive(1'b0, 32'd0, 32'h8000_0000, "R2 one half exp 126");
        drive(1'b0, 32'd0, 32'd1, "R4 lowest bit exp 95");
        drive(1'b1, 32'd0, 32'h0000_0005, "R4 zero padding");
        drive(1'b0, 32'd0, 32'h00C0_0001, "R4 23 bits below lead");
        drive(1'b0, 32'd0, 32'd0, "R5 positive zero");
        drive(1'b1, 32'd0, 32'd0, "R5 negative zero");
        // back-to-back inputs
        @(posedge clk);
        #2;
        for (int j = 0; j < 6; j++) begin
          expItem_t it;
          logic [31:0] a, b;
          a = 32'h0001_0000 >> (3 * j);
          b = 32'h9E37_79B9 * (j + 1);
          it.word = refConv(j[0], a, b);
          it.tag  = "R6 back-to-back";
          expQ.push_back(it);
          inValid = 1'b1; inSign = j[0]; inInt = a; inFrac = b;
          @(posedge clk);
          #2;
        end
        inValid = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        check(expQ.size() == 0, "R6 all results delivered", 32'(expQ.size()), 32'd0);
      end
      begin
        repeat (5000) @(posedge clk);
        check(1'b0, "watchdog expired", 32'd0, 32'd1);
      end
    join_any
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule